// File: doc/BRIEF.md
# Two-Stage Digital Gain and Offset Corrector

This block applies a linear correction to a stream of signed 16-bit sample words, one channel-tagged sample per clock. The converter result occupies the upper 14 bits of each word, so raw inputs carry two zero bits at the bottom. Each sample is first scaled by a factory calibration gain and then by a user gain. Both gains are fixed-point numbers in which 1024 stands for one. The sum of a calibration offset and a user offset is then subtracted. The bits that the gain scaling produces below the converter's resolution are kept in the output word and are not rounded away.

Every channel holds its own four coefficients and a bypass flag. When the flag is set, the calibration gain and offset are dropped and only the user terms apply, which lets software reach the raw converter code. Coefficients are loaded through a single-cycle write port, and each write also sets the channel's bypass flag. Results that fall outside the signed 16-bit range are clamped to the nearest limit, and a per-sample overflow flag is raised.

Top module: `gain_offset_corrector`

## Requirements
- R1: After reset every channel holds calibration gain 1024, calibration offset 0, user gain 1024, user offset 0 and bypass clear, so each sample leaves unchanged. While reset is held, out_valid and out_ovf are low.
- R2: A sample accepted with in_valid high appears on the outputs exactly three clock cycles later, with out_valid high and out_chan equal to the accepted in_chan. In cycles without an accepted sample three cycles earlier, out_valid is low.
- R3: Gains are unsigned 16-bit values in which 1024 means unity. For example, a gain of 512 halves the sample and a gain of 0 gives 0.
- R4: With bypass clear, the output is floor(floor(raw*cal_gain/1024)*user_gain/1024) - cal_offset - user_offset before saturation. Each division rounds toward negative infinity. Offsets are signed 16-bit values.
- R5: With bypass set, the output is floor(raw*user_gain/1024) - user_offset. The calibration gain and offset have no effect.
- R6: With bypass set, user gain 1024 and user offset 0, the output equals the raw input word.
- R7: The gain product's low bits are kept. For example, raw 0x0400 with a gain of 1063 gives 0x0427.
- R8: A result above 32767 leaves as 0x7FFF, and a result below -32768 leaves as 0x8000. In both cases out_ovf is high with that sample. A result inside the range, the limits included, has out_ovf low.
- R9: A coefficient write presented in a cycle takes effect for samples presented in later cycles. A sample presented in the same cycle as the write uses the previous values.
- R10: A write changes only the channel selected by cfg_chan. Other channels keep their coefficients and bypass flags.
- R11: cfg_sel selects the target of a write: 0 is the calibration gain, 1 the calibration offset, 2 the user gain and 3 the user offset. Every write also loads cfg_bypass into the selected channel's bypass flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample present on in_sample |
| in_chan | input | CH_W (2) | Channel of the input sample |
| in_sample | input | SAMPLE_W (16) | Raw two's complement sample |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_sel | input | 2 | Coefficient selector (see R11) |
| cfg_chan | input | CH_W (2) | Channel written |
| cfg_bypass | input | 1 | Bypass flag loaded on each write |
| cfg_data | input | COEF_W (16) | Coefficient value |
| out_valid | output | 1 | Corrected sample present |
| out_chan | output | CH_W (2) | Channel of the corrected sample |
| out_sample | output | SAMPLE_W (16) | Corrected, saturated sample |
| out_ovf | output | 1 | Saturation occurred on this sample |

## Verification
The bench targets five corner cases.

- Saturation at both limits and exactly on them. A design that wrapped instead of clamping would show a sign flip at full scale, and one with an off-by-one comparison would flag overflow on -32768 or 32767.
- Negative samples with gains just below unity. These tell flooring apart from truncation toward zero, which would return -3 instead of -4 for raw -4 with gain 1023.
- A write and a sample presented in the same cycle. A design that forwarded the new coefficient, or fetched the user gain late in the pipeline, would correct that sample with the wrong value.
- Bypass with large calibration terms loaded. A leaky bypass would still scale the sample or shift it by the calibration offset.
- Writes to neighbouring channels and writes that clear bypass. A decoder fault would show up as a sample corrected with another channel's values.

// File: rtl/gaincorr_pkg.sv
package gaincorr_pkg;

    // Coefficient selector encoding on the write port.
    typedef enum logic [1:0] {
        SEL_CAL_GAIN = 2'd0,
        SEL_CAL_OFS  = 2'd1,
        SEL_USR_GAIN = 2'd2,
        SEL_USR_OFS  = 2'd3
    } coef_sel_e;

    localparam int DEF_SAMPLE_W = 16;
    localparam int DEF_COEF_W   = 16;
    localparam int DEF_FRAC_W   = 10;

endpackage

// File: rtl/gc_coef_bank.sv
module gc_coef_bank
    import gaincorr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int COEF_W = 16,
    parameter int FRAC_W = 10,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CH_W-1:0]   cfg_chan,
    input  logic              cfg_bypass,
    input  logic [COEF_W-1:0] cfg_data,
    input  logic [CH_W-1:0]   rd_chan,
    output logic [COEF_W-1:0] rd_cal_gain,
    output logic [COEF_W-1:0] rd_cal_ofs,
    output logic [COEF_W-1:0] rd_usr_gain,
    output logic [COEF_W-1:0] rd_usr_ofs,
    output logic              rd_bypass
);

    localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << FRAC_W;

    typedef struct packed {
        logic [COEF_W-1:0] cal_gain;
        logic [COEF_W-1:0] cal_ofs;
        logic [COEF_W-1:0] usr_gain;
        logic [COEF_W-1:0] usr_ofs;
        logic              bypass;
    } entry_t;

    localparam entry_t RESET_ENTRY = '{
        cal_gain: UNITY,
        cal_ofs:  '0,
        usr_gain: UNITY,
        usr_ofs:  '0,
        bypass:   1'b0
    };

    entry_t [NUM_CH-1:0] bank_d;
    entry_t [NUM_CH-1:0] bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int c = 0; c < NUM_CH; c++) begin
            if (cfg_we && (cfg_chan == CH_W'(c))) begin
                unique case (coef_sel_e'(cfg_sel))
                    SEL_CAL_GAIN: bank_d[c].cal_gain = cfg_data;
                    SEL_CAL_OFS:  bank_d[c].cal_ofs  = cfg_data;
                    SEL_USR_GAIN: bank_d[c].usr_gain = cfg_data;
                    SEL_USR_OFS:  bank_d[c].usr_ofs  = cfg_data;
                    default:      bank_d[c].cal_gain = bank_q[c].cal_gain;
                endcase
                bank_d[c].bypass = cfg_bypass;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) begin
                bank_q[c] <= RESET_ENTRY;
            end
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rd_cal_gain = bank_q[rd_chan].cal_gain;
    assign rd_cal_ofs  = bank_q[rd_chan].cal_ofs;
    assign rd_usr_gain = bank_q[rd_chan].usr_gain;
    assign rd_usr_ofs  = bank_q[rd_chan].usr_ofs;
    assign rd_bypass   = bank_q[rd_chan].bypass;

    // R11: a calibration gain write lands in the addressed entry.
    assert_cal_gain_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == SEL_CAL_GAIN) |=> bank_q[$past(cfg_chan)].cal_gain == $past(cfg_data));

    // R11: a user offset write lands, together with the bypass flag.
    assert_usr_ofs_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == SEL_USR_OFS) |=>
            (bank_q[$past(cfg_chan)].usr_ofs == $past(cfg_data) &&
             bank_q[$past(cfg_chan)].bypass == $past(cfg_bypass)));

    // R10: without a write, no entry moves.
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(bank_q));

endmodule

// File: rtl/gc_mul_stage.sv
module gc_mul_stage #(
    parameter int IN_W   = 16,
    parameter int COEF_W = 16,
    parameter int FRAC_W = 10,
    localparam int PROD_W = IN_W + COEF_W + 1,
    localparam int OUT_W  = PROD_W - FRAC_W
) (
    input  logic [IN_W-1:0]   din,
    input  logic [COEF_W-1:0] gain,
    output logic [OUT_W-1:0]  dout
);

    logic signed [PROD_W-1:0] a_ext;
    logic signed [PROD_W-1:0] b_ext;
    logic signed [PROD_W-1:0] prod;

    // Signed sample times unsigned gain, then floor division by 2^FRAC_W.
    assign a_ext = {{(PROD_W-IN_W){din[IN_W-1]}}, din};
    assign b_ext = {{(PROD_W-COEF_W){1'b0}}, gain};
    assign prod  = a_ext * b_ext;
    assign dout  = OUT_W'(prod >>> FRAC_W);

endmodule

// File: rtl/gc_saturate.sv
module gc_saturate #(
    parameter int IN_W  = 31,
    parameter int OUT_W = 16,
    localparam int HI_W = IN_W - OUT_W + 1
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout,
    output logic             ovf
);

    localparam logic [OUT_W-1:0] POS_LIM = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] NEG_LIM = {1'b1, {(OUT_W-1){1'b0}}};

    logic [HI_W-1:0] hi_bits;

    assign hi_bits = din[IN_W-1:OUT_W-1];
    assign ovf     = !((&hi_bits) || !(|hi_bits));
    assign dout    = ovf ? (din[IN_W-1] ? NEG_LIM : POS_LIM) : din[OUT_W-1:0];

endmodule

// File: rtl/gain_offset_corrector.sv
module gain_offset_corrector
    import gaincorr_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int COEF_W   = DEF_COEF_W,
    parameter int FRAC_W   = DEF_FRAC_W,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [CH_W-1:0]     in_chan,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_sel,
    input  logic [CH_W-1:0]     cfg_chan,
    input  logic                cfg_bypass,
    input  logic [COEF_W-1:0]   cfg_data,
    output logic                out_valid,
    output logic [CH_W-1:0]     out_chan,
    output logic [SAMPLE_W-1:0] out_sample,
    output logic                out_ovf
);

    localparam int M1_W  = SAMPLE_W + COEF_W + 1 - FRAC_W;
    localparam int M2_W  = M1_W + COEF_W + 1 - FRAC_W;
    localparam int OFS_W = COEF_W + 1;
    localparam int SUM_W = M2_W + 1;
    localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << FRAC_W;
    localparam logic [SAMPLE_W-1:0] POS_LIM = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam logic [SAMPLE_W-1:0] NEG_LIM = {1'b1, {(SAMPLE_W-1){1'b0}}};

    typedef struct packed {
        logic              vld;
        logic [CH_W-1:0]   chan;
        logic [M1_W-1:0]   prod;
        logic [COEF_W-1:0] usr_gain;
        logic [OFS_W-1:0]  ofs;
    } st1_t;

    typedef struct packed {
        logic             vld;
        logic [CH_W-1:0]  chan;
        logic [M2_W-1:0]  prod;
        logic [OFS_W-1:0] ofs;
    } st2_t;

    typedef struct packed {
        logic                vld;
        logic [CH_W-1:0]     chan;
        logic [SAMPLE_W-1:0] sample;
        logic                ovf;
    } st3_t;

    typedef struct packed {
        st1_t s1;
        st2_t s2;
        st3_t s3;
    } pipe_t;

    pipe_t pipe_d;
    pipe_t pipe_q;

    logic [COEF_W-1:0]   rd_cal_gain;
    logic [COEF_W-1:0]   rd_cal_ofs;
    logic [COEF_W-1:0]   rd_usr_gain;
    logic [COEF_W-1:0]   rd_usr_ofs;
    logic                rd_bypass;
    logic [COEF_W-1:0]   gain_a;
    logic [OFS_W-1:0]    ofs_cal_ext;
    logic [OFS_W-1:0]    ofs_usr_ext;
    logic [M1_W-1:0]     m1_prod;
    logic [M2_W-1:0]     m2_prod;
    logic [SUM_W-1:0]    sum_pre;
    logic [SAMPLE_W-1:0] sat_out;
    logic                sat_ovf;
    logic [M1_W-1:0]     raw_ext;

    gc_coef_bank #(
        .NUM_CH (NUM_CH),
        .COEF_W (COEF_W),
        .FRAC_W (FRAC_W)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_chan    (cfg_chan),
        .cfg_bypass  (cfg_bypass),
        .cfg_data    (cfg_data),
        .rd_chan     (in_chan),
        .rd_cal_gain (rd_cal_gain),
        .rd_cal_ofs  (rd_cal_ofs),
        .rd_usr_gain (rd_usr_gain),
        .rd_usr_ofs  (rd_usr_ofs),
        .rd_bypass   (rd_bypass)
    );

    // Bypass replaces the calibration gain by unity and drops its offset.
    assign gain_a      = rd_bypass ? UNITY : rd_cal_gain;
    assign ofs_cal_ext = rd_bypass ? '0 : {rd_cal_ofs[COEF_W-1], rd_cal_ofs};
    assign ofs_usr_ext = {rd_usr_ofs[COEF_W-1], rd_usr_ofs};

    gc_mul_stage #(
        .IN_W   (SAMPLE_W),
        .COEF_W (COEF_W),
        .FRAC_W (FRAC_W)
    ) u_mul_cal (
        .din  (in_sample),
        .gain (gain_a),
        .dout (m1_prod)
    );

    gc_mul_stage #(
        .IN_W   (M1_W),
        .COEF_W (COEF_W),
        .FRAC_W (FRAC_W)
    ) u_mul_usr (
        .din  (pipe_q.s1.prod),
        .gain (pipe_q.s1.usr_gain),
        .dout (m2_prod)
    );

    assign sum_pre = {pipe_q.s2.prod[M2_W-1], pipe_q.s2.prod}
                   - {{(SUM_W-OFS_W){pipe_q.s2.ofs[OFS_W-1]}}, pipe_q.s2.ofs};

    gc_saturate #(
        .IN_W  (SUM_W),
        .OUT_W (SAMPLE_W)
    ) u_sat (
        .din  (sum_pre),
        .dout (sat_out),
        .ovf  (sat_ovf)
    );

    always_comb begin
        pipe_d = pipe_q;
        // Stage 1: calibration multiply; coefficients captured with the sample.
        pipe_d.s1.vld      = in_valid;
        pipe_d.s1.chan     = in_chan;
        pipe_d.s1.prod     = m1_prod;
        pipe_d.s1.usr_gain = rd_usr_gain;
        pipe_d.s1.ofs      = ofs_cal_ext + ofs_usr_ext;
        // Stage 2: user multiply.
        pipe_d.s2.vld      = pipe_q.s1.vld;
        pipe_d.s2.chan     = pipe_q.s1.chan;
        pipe_d.s2.prod     = m2_prod;
        pipe_d.s2.ofs      = pipe_q.s1.ofs;
        // Stage 3: offset subtraction and clamp.
        pipe_d.s3.vld      = pipe_q.s2.vld;
        pipe_d.s3.chan     = pipe_q.s2.chan;
        pipe_d.s3.sample   = sat_out;
        pipe_d.s3.ovf      = sat_ovf && pipe_q.s2.vld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid  = pipe_q.s3.vld;
    assign out_chan   = pipe_q.s3.chan;
    assign out_sample = pipe_q.s3.sample;
    assign out_ovf    = pipe_q.s3.ovf;

    assign raw_ext = {{(M1_W-SAMPLE_W){in_sample[SAMPLE_W-1]}}, in_sample};

    // R2: an output sample traces back to an accepted input three cycles earlier.
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 3));

    // R2: the channel tag travels with the sample.
    assert_chan_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_chan == $past(in_chan, 3));

    // R8: a flagged sample sits on one of the two limits.
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ovf) |-> (out_sample == POS_LIM || out_sample == NEG_LIM));

    // R8: no overflow indication without a sample.
    assert_ovf_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_ovf);

    // R5: with bypass the first stage passes the raw word unscaled.
    assert_bypass_first_stage_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rd_bypass) |=> pipe_q.s1.prod == $past(raw_ext));

endmodule

// File: tb/gain_offset_corrector_tb_top.sv
`timescale 1ns/1ps
module gain_offset_corrector_tb_top;

    localparam int NUM_CH = 4;
    localparam int CH_W   = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [CH_W-1:0] in_chan = '0;
    logic [15:0]     in_sample = '0;
    logic            cfg_we = 1'b0;
    logic [1:0]      cfg_sel = '0;
    logic [CH_W-1:0] cfg_chan = '0;
    logic            cfg_bypass = 1'b0;
    logic [15:0]     cfg_data = '0;
    logic            out_valid;
    logic [CH_W-1:0] out_chan;
    logic [15:0]     out_sample;
    logic            out_ovf;

    always #2 clk = ~clk;

    gain_offset_corrector #(.NUM_CH(NUM_CH)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
        .in_sample(in_sample), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_chan(cfg_chan), .cfg_bypass(cfg_bypass), .cfg_data(cfg_data),
        .out_valid(out_valid), .out_chan(out_chan), .out_sample(out_sample),
        .out_ovf(out_ovf)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_tag = "R1";

    int  m_cg [NUM_CH];
    int  m_co [NUM_CH];
    int  m_ug [NUM_CH];
    int  m_uo [NUM_CH];
    bit  m_byp[NUM_CH];
    bit    e_vld [3];
    int    e_chan[3];
    int    e_samp[3];
    bit    e_ovf [3];
    string e_tag [3];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Model of R3/R4/R5/R7/R8 with floor division and clamping.
    function automatic void predict(input int raw, input int ch, output int res, output bit ov);
        longint p;
        if (m_byp[ch]) p = ((longint'(raw) * m_ug[ch]) >>> 10) - m_uo[ch];
        else p = ((((longint'(raw) * m_cg[ch]) >>> 10) * m_ug[ch]) >>> 10) - m_co[ch] - m_uo[ch];
        ov = 1'b0;
        res = int'(p);
        if (p > 32767) begin res = 32767; ov = 1'b1; end
        if (p < -32768) begin res = -32768; ov = 1'b1; end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) begin
                m_cg[c] = 1024; m_co[c] = 0; m_ug[c] = 1024; m_uo[c] = 0; m_byp[c] = 0;
            end
            for (int i = 0; i < 3; i++) e_vld[i] = 0;
        end else begin
            for (int i = 2; i > 0; i--) begin
                e_vld[i] = e_vld[i-1]; e_chan[i] = e_chan[i-1];
                e_samp[i] = e_samp[i-1]; e_ovf[i] = e_ovf[i-1]; e_tag[i] = e_tag[i-1];
            end
            e_vld[0] = in_valid;
            e_chan[0] = int'(in_chan);
            e_tag[0] = cur_tag;
            e_samp[0] = 0;
            e_ovf[0] = 0;
            if (in_valid) predict(int'($signed(in_sample)), int'(in_chan), e_samp[0], e_ovf[0]);
            // R9: the update follows the prediction of the same cycle.
            if (cfg_we) begin
                case (cfg_sel)
                    2'd0: m_cg[cfg_chan] = int'(cfg_data);
                    2'd1: m_co[cfg_chan] = int'($signed(cfg_data));
                    2'd2: m_ug[cfg_chan] = int'(cfg_data);
                    default: m_uo[cfg_chan] = int'($signed(cfg_data));
                endcase
                m_byp[cfg_chan] = cfg_bypass;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(out_valid == e_vld[2], "R2", "out_valid", out_valid, e_vld[2]);
            if (e_vld[2]) begin
                chk(int'(out_chan) == e_chan[2], "R2", "out_chan", out_chan, e_chan[2]);
                chk(int'($signed(out_sample)) == e_samp[2], e_tag[2], "out_sample",
                    int'($signed(out_sample)), e_samp[2]);
                chk(out_ovf == e_ovf[2], "R8", "out_ovf", out_ovf, e_ovf[2]);
            end
        end
    end

    task automatic drive(input bit v, input int ch, input logic [15:0] raw,
                         input bit we, input int sel, input int wch, input bit byp,
                         input logic [15:0] data);
        @(negedge clk);
        in_valid = v; in_chan = CH_W'(ch); in_sample = raw;
        cfg_we = we; cfg_sel = 2'(sel); cfg_chan = CH_W'(wch); cfg_bypass = byp; cfg_data = data;
    endtask

    task automatic send(input int ch, input logic [15:0] raw);
        drive(1, ch, raw, 0, 0, 0, 0, 16'h0);
    endtask

    task automatic wr(input int sel, input int wch, input bit byp, input logic [15:0] data);
        drive(0, 0, 16'h0, 1, sel, wch, byp, data);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 16'h0, 0, 0, 0, 0, 16'h0);
    endtask

    initial begin
        int seed;
        seed = int'($urandom(32'd20245));
        repeat (3) @(negedge clk);
        // R1: quiet outputs during reset.
        chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        chk(out_ovf == 1'b0, "R1", "out_ovf in reset", out_ovf, 0);
        @(negedge clk);
        rst_n = 1'b1;

        cur_tag = "R1";
        send(0, 16'h1230); send(1, 16'hC004); send(2, 16'h7FFC); send(3, 16'h8000);
        idle(1);

        cur_tag = "R3";
        wr(0, 0, 0, 16'd512);
        send(0, 16'h2000); send(0, 16'hE000);
        wr(0, 0, 0, 16'd0);
        send(0, 16'h1234 & 16'hFFFC);

        cur_tag = "R7";
        wr(0, 1, 0, 16'd1063);
        send(1, 16'h0400); send(1, 16'h0010); send(1, 16'h001C);

        cur_tag = "R4";
        wr(0, 1, 0, 16'd1023);
        send(1, 16'hFFFC); send(1, 16'hFFF8);
        wr(2, 1, 0, 16'd1500); wr(1, 1, 0, 16'hFF38); wr(3, 1, 0, 16'd77);
        send(1, 16'h1004); send(1, 16'hA000);

        cur_tag = "R5";
        wr(0, 2, 0, 16'd3000); wr(1, 2, 0, 16'd500);
        wr(2, 2, 1, 16'd2048);
        send(2, 16'h0100); send(2, 16'hF000);
        wr(3, 2, 1, 16'hFFF6);
        send(2, 16'h0100);

        cur_tag = "R6";
        wr(0, 3, 0, 16'd700); wr(1, 3, 0, 16'd9); wr(2, 3, 1, 16'd1024);
        send(3, 16'h5554); send(3, 16'h8000); send(3, 16'h7FFC);

        cur_tag = "R8";
        wr(0, 0, 0, 16'd2048);
        send(0, 16'h7FFC); send(0, 16'h8000); send(0, 16'h4000); send(0, 16'h3FFC); send(0, 16'hC000);
        wr(0, 0, 0, 16'd1024); wr(3, 0, 0, 16'd1);
        send(0, 16'h8000);
        wr(3, 0, 0, 16'hFFFF);
        send(0, 16'h7FFC); send(0, 16'h8000);
        wr(3, 0, 0, 16'h0);
        send(0, 16'h8000);

        cur_tag = "R9";
        drive(1, 0, 16'h0100, 1, 0, 0, 0, 16'd4096);
        send(0, 16'h0100);
        drive(1, 0, 16'h0200, 1, 2, 0, 0, 16'd256);
        send(0, 16'h0200);

        cur_tag = "R10";
        wr(0, 1, 0, 16'd333); wr(3, 1, 1, 16'd1111);
        send(0, 16'h0800); send(2, 16'h0800); send(3, 16'h0800);

        cur_tag = "R11";
        wr(0, 3, 0, 16'd2000); wr(1, 3, 0, 16'd40); wr(2, 3, 0, 16'd512); wr(3, 3, 0, 16'hFFEC);
        send(3, 16'h1000);
        wr(1, 3, 1, 16'd40);
        send(3, 16'h1000);
        idle(4);

        cur_tag = "R4";
        for (int n = 0; n < 600; n++) begin
            int r;
            int kind;
            r = int'($urandom());
            kind = int'($urandom_range(0, 9));
            if (kind < 2) begin
                int sel;
                logic [15:0] d;
                sel = int'($urandom_range(0, 3));
                if (sel == 0 || sel == 2) d = 16'($urandom_range(0, 2600));
                else if ($urandom_range(0, 2) == 0) d = 16'($urandom());
                else d = 16'($signed(int'($urandom_range(0, 400)) - 200));
                drive(kind == 0, r % NUM_CH, {r[31:18], 2'b00}, 1, sel,
                      int'($urandom_range(0, NUM_CH-1)), $urandom_range(0, 3) == 0, d);
            end else if (kind < 8) begin
                send(r % NUM_CH, {r[31:18], 2'b00});
            end else begin
                idle(1);
            end
        end
        idle(5);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule